// File: doc/BRIEF.md
# Watchdog Counter with Bark and Bite Stages

This block is a watchdog for the slow always-on clock domain. A free-running counter, `CNT_W` bits wide (32 by default), advances by one on every clock cycle while the watchdog is enabled. Software keeps it alive by pulsing a pet input, which returns the count to zero. The count is compared against two thresholds.

The first threshold is the bark. Reaching it latches a level interrupt. If wakeup is enabled, the same latched event also raises a wakeup request to the power controller, so that a sleeping system can wake and service the watchdog. The interrupt and the wakeup stay high until software acknowledges them or the block is reset.

The second threshold is the bite. It is normally programmed above the bark threshold. Reaching it raises a reset request that only a reset clears. All pins are plain control and status levels: nothing flows through the block as data, so there is no valid/ready handshake and no back-pressure to describe.

Top module: `wdog_bark_core`

## Requirements
- R1: While `rst_ni` is low, the count is zero and `bark_irq_o`, `bark_wake_o` and `bite_rst_o` are all low.
- R2: At each rising clock edge with `enable_i` high and `pet_i` low, the count increases by exactly one.
- R3: The count saturates at all ones (2^CNT_W - 1) and never wraps to zero while enabled.
- R4: `pet_i` high at an edge sets the count to zero, taking priority over counting, and does not clear an already latched bark interrupt.
- R5: When an edge samples `enable_i` high and the count greater than or equal to `bark_thresh_i`, `bark_irq_o` is high from that edge onward.
- R6: `bark_wake_o` equals `bark_irq_o` AND `wake_en_i` in every cycle, with no register between them.
- R7: Once high, `bark_irq_o` stays high until reset or until an edge that samples `bark_ack_i` high. The acknowledge has no effect at an edge where the R5 condition also holds: setting wins.
- R8: When an edge samples `enable_i` high and the count greater than or equal to `bite_thresh_i`, `bite_rst_o` goes high. It stays high until reset and is unaffected by `pet_i` and `bark_ack_i`.
- R9: While `enable_i` is low, the count holds its value and neither threshold can raise an output.
- R10: Lowering `wake_en_i` drops `bark_wake_o` in the same cycle and leaves `bark_irq_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Always-on domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Lets the counter run and the comparators fire |
| pet_i | input | 1 | Returns the count to zero |
| bark_thresh_i | input | CNT_W | First-stage (bark) threshold |
| bite_thresh_i | input | CNT_W | Second-stage (bite) threshold |
| wake_en_i | input | 1 | Lets the bark event drive the wakeup request |
| bark_ack_i | input | 1 | Software acknowledge of the bark interrupt |
| bark_irq_o | output | 1 | Latched bark interrupt level |
| bark_wake_o | output | 1 | Bark wakeup request to the power controller |
| bite_rst_o | output | 1 | Latched reset request |

## Verification
The assertions assume that every input is a known value sampled at the rising edge, and that thresholds and control bits may change between any two edges. They make no assumption about the order of the bark and bite thresholds, or about how long a pet or acknowledge stays high. The bench drives all inputs on the falling edge from a fixed-seed random stream. It mixes sparse pets and acknowledges with thresholds kept small, so that both stages fire often. Directed runs use a narrow counter instance so that saturation can be reached, and they cover the acknowledge-versus-set collision at the edge where both occur.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  // How a latched threshold stage may be cleared besides reset.
  typedef enum logic [0:0] {
    CLR_BY_ACK   = 1'b0,
    CLR_BY_RESET = 1'b1
  } stage_clr_e;
endpackage

// File: rtl/wdog_count.sv
`timescale 1ns/1ps
module wdog_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             pet_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  logic at_max;
  assign at_max = (count_o == CntMax);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
    end else if (pet_i) begin
      count_o <= '0;
    end else if (run_i && !at_max) begin
      count_o <= count_o + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_stage.sv
`timescale 1ns/1ps
module wdog_stage
  import wdog_pkg::*;
#(
  parameter int         CNT_W    = 32,
  parameter stage_clr_e CLR_MODE = CLR_BY_ACK
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic             ack_i,
  output logic             flag_o
);
  logic hit;
  logic clr;

  assign hit = arm_i && (count_i >= thresh_i);

  generate
    if (CLR_MODE == CLR_BY_ACK) begin : g_ackable
      assign clr = ack_i;
    end else begin : g_latched
      assign clr = 1'b0 & ack_i;
    end
  endgenerate

  // A new hit outranks a clear in the same cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
    end else if (hit) begin
      flag_o <= 1'b1;
    end else if (clr) begin
      flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_bark_core.sv
`timescale 1ns/1ps
module wdog_bark_core
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             pet_i,
  input  logic [CNT_W-1:0] bark_thresh_i,
  input  logic [CNT_W-1:0] bite_thresh_i,
  input  logic             wake_en_i,
  input  logic             bark_ack_i,
  output logic             bark_irq_o,
  output logic             bark_wake_o,
  output logic             bite_rst_o
);
  logic [CNT_W-1:0] cnt_q;

  wdog_count #(.CNT_W(CNT_W)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (enable_i),
    .pet_i   (pet_i),
    .count_o (cnt_q)
  );

  wdog_stage #(.CNT_W(CNT_W), .CLR_MODE(CLR_BY_ACK)) u_bark (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (enable_i),
    .count_i  (cnt_q),
    .thresh_i (bark_thresh_i),
    .ack_i    (bark_ack_i),
    .flag_o   (bark_irq_o)
  );

  wdog_stage #(.CNT_W(CNT_W), .CLR_MODE(CLR_BY_RESET)) u_bite (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (enable_i),
    .count_i  (cnt_q),
    .thresh_i (bite_thresh_i),
    .ack_i    (1'b0),
    .flag_o   (bite_rst_o)
  );

  // Wakeup follows the latched bark, gated with no register in between.
  assign bark_wake_o = bark_irq_o & wake_en_i;
endmodule

// File: rtl/wdog_bark_core_chk.sv
`timescale 1ns/1ps
module wdog_bark_core_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             pet_i,
  input logic [CNT_W-1:0] bark_thresh_i,
  input logic [CNT_W-1:0] bite_thresh_i,
  input logic             wake_en_i,
  input logic             bark_ack_i,
  input logic             bark_irq_o,
  input logic             bark_wake_o,
  input logic             bite_rst_o,
  input logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (cnt_q == '0 && !bark_irq_o && !bite_rst_o));

  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !pet_i && cnt_q != CntMax) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_saturate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CntMax && !pet_i) |=> (cnt_q == CntMax));

  assert_pet_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pet_i |=> (cnt_q == '0));

  assert_bark_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && cnt_q >= bark_thresh_i) |=> bark_irq_o);

  assert_wake_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bark_wake_o |-> (bark_irq_o && wake_en_i));

  assert_bark_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bark_irq_o && !bark_ack_i) |=> bark_irq_o);

  assert_bark_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bark_ack_i && !(enable_i && cnt_q >= bark_thresh_i)) |=> !bark_irq_o);

  assert_bite_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && cnt_q >= bite_thresh_i) |=> bite_rst_o);

  assert_bite_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bite_rst_o |=> bite_rst_o);

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !pet_i) |=> $stable(cnt_q));

  assert_idle_no_bite_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !bite_rst_o) |=> !bite_rst_o);

  assert_wake_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bark_irq_o && wake_en_i) |-> bark_wake_o);
endmodule

bind wdog_bark_core wdog_bark_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .enable_i      (enable_i),
  .pet_i         (pet_i),
  .bark_thresh_i (bark_thresh_i),
  .bite_thresh_i (bite_thresh_i),
  .wake_en_i     (wake_en_i),
  .bark_ack_i    (bark_ack_i),
  .bark_irq_o    (bark_irq_o),
  .bark_wake_o   (bark_wake_o),
  .bite_rst_o    (bite_rst_o),
  .cnt_q         (cnt_q)
);

// File: tb/wdog_bark_core_test.sv
`timescale 1ns/1ps
module wdog_bark_core_test;
  localparam int W = 10;
  localparam logic [W-1:0] MAXV = '1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         en = 1'b0, pet = 1'b0, ack = 1'b0, wen = 1'b0;
  logic [W-1:0] bark_thr = '0, bite_thr = '0;
  logic         irq, wake, bite;

  // Reference state, built from the requirements.
  logic [W-1:0] m_cnt = '0;
  logic         m_bark = 1'b0, m_bite = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  int seed_v;

  wdog_bark_core #(.CNT_W(W)) uut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .enable_i      (en),
    .pet_i         (pet),
    .bark_thresh_i (bark_thr),
    .bite_thresh_i (bite_thr),
    .wake_en_i     (wen),
    .bark_ack_i    (ack),
    .bark_irq_o    (irq),
    .bark_wake_o   (wake),
    .bite_rst_o    (bite)
  );

  task automatic check1(string tag, string what, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check1(tag, "bark_irq_o", irq, m_bark);
    check1(tag, "bark_wake_o", wake, m_bark & wen);
    check1(tag, "bite_rst_o", bite, m_bite);
  endtask

  function automatic logic [W-1:0] next_cnt(logic [W-1:0] c, logic e, logic p);
    if (p) return '0;
    if (e && c != MAXV) return c + 1'b1;
    return c;
  endfunction

  function automatic logic next_bark(logic b, logic [W-1:0] c, logic e, logic a,
                                     logic [W-1:0] thr);
    if (e && c >= thr) return 1'b1;
    if (a) return 1'b0;
    return b;
  endfunction

  // Called at a falling edge; drives inputs, checks, advances one cycle.
  task automatic step(string tag, logic e, logic p, logic a, logic w);
    logic [W-1:0] nc;
    logic nb, nt;
    en = e; pet = p; ack = a; wen = w;
    #1;
    check_all(tag);
    nc = next_cnt(m_cnt, e, p);
    nb = next_bark(m_bark, m_cnt, e, a, bark_thr);
    nt = m_bite | (e && m_cnt >= bite_thr);
    @(posedge clk);
    @(negedge clk);
    m_cnt = nc; m_bark = nb; m_bite = nt;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 0; pet = 0; ack = 0; wen = 0;
    m_cnt = '0; m_bark = 1'b0; m_bite = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    seed_v = $urandom(32'd4711);

    // R1 reset state, then R2/R5/R6 basic run
    do_reset();
    bark_thr = 10'd20; bite_thr = 10'd40;
    for (int i = 0; i < 20; i++) step("R2", 1, 0, 0, 1);
    check1("R5", "bark_irq_o before threshold", irq, 1'b0);
    step("R5", 1, 0, 0, 1);
    check1("R5", "bark_irq_o at threshold", irq, 1'b1);
    check1("R6", "bark_wake_o with wake enabled", wake, 1'b1);

    // R10 wake disable drops wake now, irq holds
    en = 1'b0; wen = 1'b0; #1;
    check1("R10", "bark_wake_o after disable", wake, 1'b0);
    check1("R10", "bark_irq_o after disable", irq, 1'b1);
    step("R10", 0, 0, 0, 0);

    // R4 pet keeps irq, then ack clears with count at zero
    step("R4", 1, 1, 0, 1);
    check1("R4", "bark_irq_o after pet", irq, 1'b1);
    step("R4", 1, 0, 1, 1);
    check1("R4", "bark_irq_o after ack post-pet", irq, 1'b0);
    for (int i = 0; i < 15; i++) step("R4", 1, 0, 0, 1);
    check1("R4", "bark_irq_o low while count small", irq, 1'b0);

    // R9 disabled: count holds, nothing fires
    for (int i = 0; i < 60; i++) step("R9", 0, 0, 0, 1);
    check1("R9", "bark_irq_o while disabled", irq, 1'b0);
    check1("R9", "bite_rst_o while disabled", bite, 1'b0);

    // R7 ack during active condition: set wins
    for (int i = 0; i < 8; i++) step("R7", 1, 0, 0, 1);
    step("R7", 1, 0, 1, 1);
    check1("R7", "bark_irq_o ack while above threshold", irq, 1'b1);

    // R8 bite, unaffected by pet and ack
    for (int i = 0; i < 20; i++) step("R8", 1, 0, 0, 1);
    check1("R8", "bite_rst_o after bite threshold", bite, 1'b1);
    step("R8", 1, 1, 1, 1);
    step("R8", 0, 0, 1, 1);
    check1("R8", "bite_rst_o after pet and ack", bite, 1'b1);
    do_reset();
    check1("R8", "bite_rst_o cleared by reset", bite, 1'b0);

    // R3 saturation: ack at max must be overridden by a still-true compare
    bark_thr = MAXV; bite_thr = MAXV;
    for (int i = 0; i < 1100; i++) step("R3", 1, 0, 0, 0);
    step("R3", 1, 0, 1, 0);
    check1("R3", "bark_irq_o after ack at saturation", irq, 1'b1);
    check1("R3", "bite_rst_o at saturation", bite, 1'b1);

    // Random mix across all requirements (R5 R7 R8 model compare)
    do_reset();
    for (int blk = 0; blk < 40; blk++) begin
      bark_thr = W'($urandom_range(0, 60));
      bite_thr = bark_thr + W'($urandom_range(0, 80));
      if (blk % 10 == 9) do_reset();
      for (int i = 0; i < 80; i++) begin
        step("R7", ($urandom_range(0, 7) != 0), ($urandom_range(0, 15) == 0),
             ($urandom_range(0, 5) == 0), ($urandom_range(0, 3) != 0));
      end
    end
    check_all("R5");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule